// File: doc/BRIEF.md
# Receive Queue with Automatic RTS/CTS Handshake

This block sits between a serial deserializer and the byte consumer of an asynchronous serial port. Each completed byte from the deserializer is written into an eight-entry queue, and the consumer pops bytes in arrival order. A two-bit code picks a fill threshold. The threshold drives a "threshold reached" flag and also the point at which the block withdraws its request-to-send line, so that the far end stops sending before the queue fills.

On the transmit side the block grants the serializer permission to start each new frame. With automatic handshaking on, permission follows the synchronized clear-to-send input, which is active low. The input is only re-evaluated while the serializer reports that it is between frames, so a frame in progress always finishes. A sticky overrun flag records bytes lost to a full queue. A sticky change flag records clear-to-send transitions, but only while automatic handshaking is off. Clear strobes empty the receive queue and issue a one-cycle flush pulse toward the transmit queue.

When the queue is disabled, the receive path acts as a single holding byte.

Top module: `rx_fifo_autoflow`

## Requirements
- R1: After reset, data_ready, trig_hit, overrun, cts_delta, tx_permit and tx_flush are 0 and rts_n is 1.
- R2: Bytes are read in the order they arrived. rd_data shows the oldest held byte, and a cycle with rd_en high while data_ready is 1 removes it. data_ready is 1 exactly when at least one byte is held.
- R3: trig_code selects the threshold: 2'b00 gives 1 byte, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 7. trig_hit is 1 while the held count is at or above the threshold.
- R4: The queue holds at most 8 bytes. A byte arriving while it is full is dropped and sets overrun, unless a pop happens in the same cycle, in which case the byte is kept. overrun stays 1 until a status_rd strobe.
- R5: With auto_flow and rts_sw both 1, rts_n is 0 while the queue is empty. rts_n goes to 1 one cycle after the count reaches the threshold. It stays 1 while the count falls back below the threshold and returns to 0 one cycle after the queue becomes empty.
- R6: With auto_flow at 0, rts_n is the inverse of rts_sw in the same cycle, whatever the fill level.
- R7: While tx_idle is 1, tx_permit becomes 1 when auto_flow is 0. When auto_flow is 1, tx_permit becomes 1 if the cts_n input, after its two-stage synchronizer, is 0, and 0 otherwise.
- R8: While tx_idle is 0, tx_permit holds its value, whatever cts_n does.
- R9: A change of the synchronized cts_n while auto_flow is 0 sets cts_delta. status_rd clears it. While auto_flow is 1, cts_delta is never set.
- R10: rx_clr empties the queue in one cycle. A byte delivered by rx_valid in the same cycle is kept as the only entry.
- R11: The rising edge of tx_clr produces a tx_flush pulse exactly one cycle long, even if tx_clr stays high.
- R12: With fifo_en at 0, the queue holds one byte and the threshold is 1 whatever trig_code is. A second byte arriving before the first is read sets overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 = eight-deep queue, 0 = single holding byte |
| trig_code | input | 2 | Threshold select |
| auto_flow | input | 1 | Enables automatic RTS/CTS handshake |
| rts_sw | input | 1 | Software request-to-send |
| rx_valid | input | 1 | Deserializer has a completed byte this cycle |
| rx_byte | input | 8 | Completed byte |
| rd_en | input | 1 | Consumer pop request |
| rd_data | output | 8 | Oldest held byte |
| data_ready | output | 1 | At least one byte held |
| trig_hit | output | 1 | Count at or above the threshold |
| overrun | output | 1 | Sticky byte-lost flag |
| status_rd | input | 1 | Status read strobe, clears overrun and cts_delta |
| rx_clr | input | 1 | Empty the receive queue |
| tx_clr | input | 1 | Transmit queue clear request |
| tx_flush | output | 1 | One-cycle transmit queue flush pulse |
| rts_n | output | 1 | Request-to-send, active low |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| tx_idle | input | 1 | Serializer is between frames |
| tx_permit | output | 1 | Serializer may start the next frame |
| cts_delta | output | 1 | Sticky clear-to-send change flag |

## Verification
A corrupted read or write pointer shows on rd_data at the very next pop, as a byte out of order against the scoreboard. A wrong count shows up in one of three ways: data_ready or trig_hit flips at the wrong push, a byte is dropped early, or overrun rises one byte too soon. A hysteresis latch that releases early lowers rts_n while bytes are still held, one cycle after the first pop below the threshold. A permit register that follows cts_n mid-frame changes tx_permit while tx_idle is low, within three cycles of the input changing.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE  = 2'b00,
        TRIG_TWO  = 2'b01,
        TRIG_FOUR = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_code_e;

    // Threshold in bytes for a trigger code; the top code sits one below full.
    function automatic int unsigned trig_bytes(input trig_code_e code,
                                               input int unsigned depth);
        case (code)
            TRIG_ONE:  return 1;
            TRIG_TWO:  return 2;
            TRIG_FOUR: return 4;
            default:   return depth - 1;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic [CNT_W-1:0] cap,
    input  logic             stat_rd,
    output logic [WIDTH-1:0] rd_data,
    output logic [CNT_W-1:0] level,
    output logic             overrun
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovr;
    } store_t;

    store_t           s_d, s_q;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic             take;
    logic             full;
    logic [WIDTH-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        wr_addr = s_q.wr;
        full    = (s_q.cnt >= cap);
        take    = pop && (s_q.cnt != '0) && !clr;
        if (clr) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.cnt = '0;
            if (push) begin
                wr_en   = 1'b1;
                wr_addr = '0;
                s_d.wr  = bump('0);
                s_d.cnt = CNT_W'(1);
            end
        end else begin
            if (push && (!full || take)) begin
                wr_en  = 1'b1;
                s_d.wr = bump(s_q.wr);
            end
            if (take) s_d.rd = bump(s_q.rd);
            s_d.cnt = s_q.cnt + CNT_W'(wr_en) - CNT_W'(take);
        end
        if (stat_rd) s_d.ovr = 1'b0;
        if (push && !wr_en) s_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= push_data;
    end

    assign rd_data = mem[s_q.rd];
    assign level   = s_q.cnt;
    assign overrun = s_q.ovr;

endmodule

// File: rtl/rxq_flow.sv
module rxq_flow #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_flow,
    input  logic             rts_sw,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] thr,
    input  logic             cts_n,
    input  logic             tx_idle,
    input  logic             stat_rd,
    input  logic             tx_clr,
    output logic             rts_n,
    output logic             rts_hold,
    output logic             tx_permit,
    output logic             cts_delta,
    output logic             tx_flush
);

    typedef struct packed {
        logic cts_s1;
        logic cts_s2;
        logic cts_last;
        logic hold;
        logic permit;
        logic delta;
        logic clr_prev;
        logic flush;
    } flow_t;

    localparam flow_t FLOW_RST = '{cts_s1: 1'b1, cts_s2: 1'b1, cts_last: 1'b1,
                                   default: 1'b0};

    flow_t f_d, f_q;

    always_comb begin
        f_d          = f_q;
        f_d.cts_s1   = cts_n;
        f_d.cts_s2   = f_q.cts_s1;
        f_d.cts_last = f_q.cts_s2;
        if (level == '0)        f_d.hold = 1'b0;
        else if (level >= thr)  f_d.hold = 1'b1;
        if (tx_idle) f_d.permit = !auto_flow || !f_q.cts_s2;
        if (stat_rd) f_d.delta = 1'b0;
        if ((f_q.cts_s2 != f_q.cts_last) && !auto_flow) f_d.delta = 1'b1;
        f_d.clr_prev = tx_clr;
        f_d.flush    = tx_clr && !f_q.clr_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= FLOW_RST;
        else        f_q <= f_d;
    end

    assign rts_n     = !(rts_sw && !(auto_flow && f_q.hold));
    assign rts_hold  = f_q.hold;
    assign tx_permit = f_q.permit;
    assign cts_delta = f_q.delta;
    assign tx_flush  = f_q.flush;

endmodule

// File: rtl/rx_fifo_autoflow.sv
module rx_fifo_autoflow
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [1:0]       trig_code,
    input  logic             auto_flow,
    input  logic             rts_sw,
    input  logic             rx_valid,
    input  logic [WIDTH-1:0] rx_byte,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             data_ready,
    output logic             trig_hit,
    output logic             overrun,
    input  logic             status_rd,
    input  logic             rx_clr,
    input  logic             tx_clr,
    output logic             tx_flush,
    output logic             rts_n,
    input  logic             cts_n,
    input  logic             tx_idle,
    output logic             tx_permit,
    output logic             cts_delta
);

    logic [CNT_W-1:0] lvl;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] cap;
    logic             rts_hold;

    assign thr = fifo_en ? CNT_W'(trig_bytes(trig_code_e'(trig_code), DEPTH)) : CNT_W'(1);
    assign cap = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);

    rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_clr),
        .push      (rx_valid),
        .push_data (rx_byte),
        .pop       (rd_en),
        .cap       (cap),
        .stat_rd   (status_rd),
        .rd_data   (rd_data),
        .level     (lvl),
        .overrun   (overrun)
    );

    rxq_flow #(.CNT_W(CNT_W)) u_flow (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_flow (auto_flow),
        .rts_sw    (rts_sw),
        .level     (lvl),
        .thr       (thr),
        .cts_n     (cts_n),
        .tx_idle   (tx_idle),
        .stat_rd   (status_rd),
        .tx_clr    (tx_clr),
        .rts_n     (rts_n),
        .rts_hold  (rts_hold),
        .tx_permit (tx_permit),
        .cts_delta (cts_delta),
        .tx_flush  (tx_flush)
    );

    assign data_ready = (lvl != '0);
    assign trig_hit   = (lvl >= thr);

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] lvl,
    input logic             rts_hold,
    input logic             overrun,
    input logic             status_rd,
    input logic             tx_idle,
    input logic             tx_permit,
    input logic             auto_flow,
    input logic             cts_delta,
    input logic             rx_clr,
    input logic             rx_valid,
    input logic             data_ready
);

    // R4
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= CNT_W'(DEPTH));

    // R4
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !status_rd |=> overrun);

    // R5
    rts_hyst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rts_hold && (lvl != '0) |=> rts_hold);

    // R8
    permit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle |=> $stable(tx_permit));

    // R9
    delta_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_flow && !cts_delta |=> !cts_delta);

    // R10
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr && !rx_valid |=> !data_ready);

endmodule

bind rx_fifo_autoflow rxq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl        (lvl),
    .rts_hold   (rts_hold),
    .overrun    (overrun),
    .status_rd  (status_rd),
    .tx_idle    (tx_idle),
    .tx_permit  (tx_permit),
    .auto_flow  (auto_flow),
    .cts_delta  (cts_delta),
    .rx_clr     (rx_clr),
    .rx_valid   (rx_valid),
    .data_ready (data_ready)
);

// File: tb/test_rx_fifo_autoflow.sv
`timescale 1ns/1ps
module test_rx_fifo_autoflow;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [1:0] trig_code = 2'b00;
    logic       auto_flow = 1'b0;
    logic       rts_sw = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       data_ready, trig_hit, overrun;
    logic       status_rd = 1'b0;
    logic       rx_clr = 1'b0;
    logic       tx_clr = 1'b0;
    logic       tx_flush, rts_n;
    logic       cts_n = 1'b1;
    logic       tx_idle = 1'b0;
    logic       tx_permit, cts_delta;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    rx_fifo_autoflow i_rx_fifo_autoflow (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_code(trig_code),
        .auto_flow(auto_flow), .rts_sw(rts_sw), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rd_en(rd_en), .rd_data(rd_data),
        .data_ready(data_ready), .trig_hit(trig_hit), .overrun(overrun),
        .status_rd(status_rd), .rx_clr(rx_clr), .tx_clr(tx_clr),
        .tx_flush(tx_flush), .rts_n(rts_n), .cts_n(cts_n), .tx_idle(tx_idle),
        .tx_permit(tx_permit), .cts_delta(cts_delta)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] expv);
        n_run++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: delivers one byte, records it in the scoreboard if it should be kept.
    task automatic push(input logic [7:0] b, input bit keep);
        rx_valid = 1'b1;
        rx_byte  = b;
        if (keep) exp_q.push_back(b);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Monitor: compares the head byte with the scoreboard, then pops it.
    task automatic pop_chk(input string req);
        logic [7:0] e;
        if (exp_q.size() == 0) begin
            chk({req, " scoreboard empty"}, 32'd0, 32'd1);
        end else begin
            e = exp_q.pop_front();
            chk(req, {24'd0, rd_data}, {24'd0, e});
        end
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic strobe_status();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    initial begin
        int thr_tab[4];
        logic [7:0] e;
        thr_tab = '{1, 2, 4, 7};
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 data_ready", data_ready, 0);
        chk("R1 trig_hit", trig_hit, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 cts_delta", cts_delta, 0);
        chk("R1 tx_permit", tx_permit, 0);
        chk("R1 tx_flush", tx_flush, 0);
        chk("R1 rts_n", rts_n, 1);

        // R5 hysteresis with threshold 4
        fifo_en = 1'b1; trig_code = 2'b10; auto_flow = 1'b1; rts_sw = 1'b1;
        idle(1);
        chk("R5 rts_n active when empty", rts_n, 0);
        push(8'hA0, 1); push(8'hA1, 1); push(8'hA2, 1);
        chk("R3 below threshold 4", trig_hit, 0);
        idle(1);
        chk("R5 rts_n below threshold", rts_n, 0);
        push(8'hA3, 1);
        chk("R3 at threshold 4", trig_hit, 1);
        idle(1);
        chk("R5 rts_n dropped at threshold", rts_n, 1);
        pop_chk("R2 order");
        idle(1);
        chk("R5 rts_n held below threshold", rts_n, 1);
        chk("R3 below threshold after pop", trig_hit, 0);
        pop_chk("R2 order"); pop_chk("R2 order"); pop_chk("R2 order");
        chk("R2 data_ready empty", data_ready, 0);
        idle(1);
        chk("R5 rts_n back after empty", rts_n, 0);

        // R3 every trigger code
        for (int c = 0; c < 4; c++) begin
            trig_code = c[1:0];
            for (int i = 0; i < thr_tab[c] - 1; i++) push(8'(16 * c + i), 1);
            if (thr_tab[c] > 1) chk($sformatf("R3 code %0d below", c), trig_hit, 0);
            push(8'hF0 | 8'(c), 1);
            chk($sformatf("R3 code %0d reached", c), trig_hit, 1);
            while (exp_q.size() > 0) pop_chk("R2 drain order");
            idle(1);
        end

        // R4 overrun and full boundary
        trig_code = 2'b11;
        for (int i = 0; i < 8; i++) push(8'h40 + 8'(i), 1);
        chk("R4 no overrun at 8", overrun, 0);
        push(8'hEE, 0);
        chk("R4 overrun set", overrun, 1);
        idle(2);
        chk("R4 overrun sticky", overrun, 1);
        strobe_status();
        chk("R4 overrun cleared", overrun, 0);
        e = exp_q.pop_front();
        chk("R4 head before push+pop", {24'd0, rd_data}, {24'd0, e});
        rx_valid = 1'b1; rx_byte = 8'h5A; rd_en = 1'b1;
        exp_q.push_back(8'h5A);
        @(negedge clk);
        rx_valid = 1'b0; rd_en = 1'b0;
        chk("R4 push with pop when full keeps byte", overrun, 0);
        while (exp_q.size() > 0) pop_chk("R4 order after full");
        chk("R2 empty after drain", data_ready, 0);

        // R10 receive clear
        push(8'h01, 1); push(8'h02, 1); push(8'h03, 1);
        exp_q.delete();
        rx_clr = 1'b1; rx_valid = 1'b1; rx_byte = 8'hC3;
        exp_q.push_back(8'hC3);
        @(negedge clk);
        rx_clr = 1'b0; rx_valid = 1'b0;
        chk("R10 byte kept during clear", data_ready, 1);
        pop_chk("R10 kept byte value");
        chk("R10 only one entry", data_ready, 0);
        push(8'h07, 0); push(8'h08, 0);
        rx_clr = 1'b1;
        @(negedge clk);
        rx_clr = 1'b0;
        chk("R10 clear empties", data_ready, 0);

        // R6 manual RTS
        auto_flow = 1'b0; rts_sw = 1'b0;
        #1 chk("R6 rts_n follows rts_sw 0", rts_n, 1);
        rts_sw = 1'b1;
        #1 chk("R6 rts_n follows rts_sw 1", rts_n, 0);
        @(negedge clk);
        for (int i = 0; i < 7; i++) push(8'h60 + 8'(i), 1);
        idle(1);
        chk("R6 level ignored without auto", rts_n, 0);
        while (exp_q.size() > 0) pop_chk("R2 drain order");

        // R7 R8 R9 transmit permission and CTS change flag
        auto_flow = 1'b1; tx_idle = 1'b1; cts_n = 1'b1;
        idle(4);
        chk("R7 permit off with cts inactive", tx_permit, 0);
        cts_n = 1'b0;
        idle(4);
        chk("R7 permit on with cts active", tx_permit, 1);
        chk("R9 no delta under auto", cts_delta, 0);
        tx_idle = 1'b0; cts_n = 1'b1;
        idle(4);
        chk("R8 permit held mid frame", tx_permit, 1);
        chk("R9 no delta under auto", cts_delta, 0);
        tx_idle = 1'b1;
        idle(2);
        chk("R7 permit off at frame boundary", tx_permit, 0);
        auto_flow = 1'b0;
        idle(2);
        chk("R7 permit on without auto", tx_permit, 1);
        chk("R9 no delta before change", cts_delta, 0);
        cts_n = 1'b0;
        idle(4);
        chk("R9 delta set", cts_delta, 1);
        strobe_status();
        chk("R9 delta cleared", cts_delta, 0);

        // R11 transmit flush pulse
        tx_clr = 1'b1;
        @(negedge clk);
        chk("R11 flush pulse", tx_flush, 1);
        @(negedge clk);
        chk("R11 flush one cycle", tx_flush, 0);
        tx_clr = 1'b0;
        idle(1);
        chk("R11 flush stays low", tx_flush, 0);

        // R12 single holding byte
        fifo_en = 1'b0; trig_code = 2'b11; auto_flow = 1'b1; rts_sw = 1'b1;
        idle(1);
        push(8'h11, 1);
        chk("R12 threshold 1", trig_hit, 1);
        idle(1);
        chk("R12 rts_n dropped at one byte", rts_n, 1);
        push(8'h22, 0);
        chk("R12 second byte overruns", overrun, 1);
        pop_chk("R12 held byte");
        chk("R12 empty", data_ready, 0);
        strobe_status();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule